// File: doc/BRIEF.md
# Audio DSP Operand Source Selector

This block is the operand front end of a microcoded audio effects processor. Each instruction step carries a 6-bit input read address. The block uses that address to pick one value from three sources: a bank of 32 memory-read latches, 16 mixer-channel samples, or 2 external samples. Each source is aligned to a shared 24-bit two's-complement format, so the downstream multiplier sees a single operand layout whatever the source.

The block also holds three small registers that later steps read back: a 24-bit Y register, a 13-bit fractional register and a 13-bit address register. Each one loads when the latch bit for it is set in the current instruction. A memory-read latch entry can be refilled from a 4-slot delayed read pipeline. The slot used is chosen by the low two bits of the step index. The sequencer strobes `step_valid` once per step with a 7-bit step index. Every register update takes place on the clock edge that closes a strobed step. Step 0 opens a new 128-step program pass.

Top module: `dsp_operand_front`

## Requirements
- R1: When `ira` is 0x00 to 0x1F, `sel_input` equals memory-read latch entry `ira` unchanged.
- R2: When `ira` is 0x20 to 0x2F, `sel_input` is mixer sample `ira-0x20` shifted left by 4. Mixer sample k is 20-bit two's complement at `mixer_in[20k+19:20k]`.
- R3: When `ira` is 0x30 or 0x31, `sel_input` is external sample `ira-0x30` shifted left by 8. External sample k is 16-bit two's complement at `ext_in[16k+15:16k]`.
- R4: When `ira` is 0x32 to 0x3F, `sel_input` is zero.
- R5: On a strobed step with `yrl` set, `y_reg` takes `sel_input` at the closing edge.
- R6: On a strobed step with `adrl` set and `shift_mode` = 3, `adrs_reg` takes `shifter_in` arithmetically shifted right by 12, sign-extended to 13 bits.
- R7: On a strobed step with `adrl` set and `shift_mode` not 3, `adrs_reg` takes `sel_input` arithmetically shifted right by 16, sign-extended to 13 bits.
- R8: On a strobed step with `frcl` set and `shift_mode` = 3, `frc_reg` takes `shifter_in[11:0]` zero-extended to 13 bits.
- R9: On a strobed step with `frcl` set and `shift_mode` not 3, `frc_reg` takes `shifter_in` arithmetically shifted right by 11 (13 bits).
- R10: On a strobed step with `iwt` set, latch entry `iwa` takes pipeline slot `step_idx[1:0]`. Slot s sits at `memval_in[24s+23:24s]`. The read of `sel_input` in the same step returns the old entry, and the new value is visible from the next step.
- R11: On a strobed step with `step_idx` = 0, each of Y, fractional and address registers whose latch bit is clear ends the step at zero. Latch entries are not cleared.
- R12: Without `step_valid`, none of the three registers and no latch entry changes, whatever the instruction bits are.
- R13: A synchronous active-high `rst` clears Y, fractional and address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Qualifies the current instruction step |
| step_idx | input | 7 | Step index within the 128-step pass |
| ira | input | 6 | Input read address |
| iwt | input | 1 | Latch-bank write enable |
| iwa | input | 5 | Latch-bank write address |
| yrl | input | 1 | Y register latch bit |
| adrl | input | 1 | Address register latch bit |
| frcl | input | 1 | Fractional register latch bit |
| shift_mode | input | 2 | Shifter mode of the instruction |
| shifter_in | input | 24 | Shifter output from the datapath |
| mixer_in | input | 320 | 16 mixer samples, 20 bits each |
| ext_in | input | 32 | 2 external samples, 16 bits each |
| memval_in | input | 96 | 4 delayed memory-read slots, 24 bits each |
| sel_input | output | 24 | Aligned selected input (combinational) |
| y_reg | output | 24 | Y register |
| frc_reg | output | 13 | Fractional register |
| adrs_reg | output | 13 | Address register |

## Verification
The assertions assume that `step_valid` stays low while `rst` is high, and that instruction fields are driven to known values on every cycle. They do not assume any ordering of addresses or latch bits. The stimulus keeps the strobe low during reset. It fills all 32 latch entries before any latch-bank read is compared, so the reference model never compares against an unwritten entry. After that fill, addresses, latch bits, shift modes and data are drawn at random across the whole 6-bit address space, with the strobe dropped on about one cycle in five. Directed steps then cover same-step write and read of one entry, the top address range, and a reset part way through the run.

// File: rtl/dsp_opfront_pkg.sv
package dsp_opfront_pkg;
  typedef enum logic [1:0] {
    SHM_SAT   = 2'd0,
    SHM_SAT2  = 2'd1,
    SHM_X2    = 2'd2,
    SHM_RAW   = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/opf_source_mux.sv
module opf_source_mux #(
  parameter int DW      = 24,
  parameter int IRA_W   = 6,
  parameter int MEMS_N  = 32,
  parameter int MIX_N   = 16,
  parameter int MIX_W   = 20,
  parameter int EXT_N   = 2,
  parameter int EXT_W   = 16
) (
  input  logic [IRA_W-1:0]       ira,
  input  logic [DW-1:0]          mem_rd,
  input  logic [MIX_N*MIX_W-1:0] mixer_in,
  input  logic [EXT_N*EXT_W-1:0] ext_in,
  output logic [DW-1:0]          sel
);
  localparam int MIX_BASE = MEMS_N;
  localparam int EXT_BASE = MEMS_N + MIX_N;
  localparam int MIX_SH   = DW - MIX_W;
  localparam int EXT_SH   = DW - EXT_W;

  logic [DW-1:0] mix_al [MIX_N];
  logic [DW-1:0] ext_al [EXT_N];

  // left alignment of every narrower source into the common width
  for (genvar m = 0; m < MIX_N; m++) begin : g_mix
    assign mix_al[m] = {mixer_in[m*MIX_W +: MIX_W], {MIX_SH{1'b0}}};
  end
  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    assign ext_al[e] = {ext_in[e*EXT_W +: EXT_W], {EXT_SH{1'b0}}};
  end

  always_comb begin
    sel = '0;
    if (int'(ira) < MIX_BASE) begin
      sel = mem_rd;
    end else begin
      for (int m = 0; m < MIX_N; m++)
        if (int'(ira) == MIX_BASE + m) sel = mix_al[m];
      for (int e = 0; e < EXT_N; e++)
        if (int'(ira) == EXT_BASE + e) sel = ext_al[e];
    end
  end
endmodule

// File: rtl/opf_latch_bank.sv
module opf_latch_bank #(
  parameter int DW     = 24,
  parameter int DEPTH  = 32,
  parameter int PIPE_N = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PAW   = $clog2(PIPE_N)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [PAW-1:0]       slot,
  input  logic [PIPE_N*DW-1:0] memval_in,
  input  logic [AW-1:0]        raddr,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wdata;

  always_comb begin
    wdata = '0;
    for (int s = 0; s < PIPE_N; s++)
      if (slot == PAW'(s)) wdata = memval_in[s*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/opf_field_regs.sv
module opf_field_regs
  import dsp_opfront_pkg::*;
#(
  parameter int DW     = 24,
  parameter int ADR_W  = 13,
  parameter int FRC_W  = 13,
  parameter int ADR_SH_S = 12,
  parameter int ADR_SH_I = 16,
  parameter int FRC_SH   = 11,
  parameter int FRC_LOW  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             first,
  input  logic             yrl,
  input  logic             adrl,
  input  logic             frcl,
  input  shift_mode_e      mode,
  input  logic [DW-1:0]    sel,
  input  logic [DW-1:0]    shifter,
  output logic [DW-1:0]    y_q,
  output logic [FRC_W-1:0] frc_q,
  output logic [ADR_W-1:0] adr_q
);
  logic             raw;
  logic [ADR_W-1:0] adr_next;
  logic [FRC_W-1:0] frc_next;

  assign raw      = (mode == SHM_RAW);
  assign adr_next = raw ? ADR_W'($signed(shifter) >>> ADR_SH_S)
                        : ADR_W'($signed(sel) >>> ADR_SH_I);
  assign frc_next = raw ? FRC_W'(shifter[FRC_LOW-1:0])
                        : FRC_W'($signed(shifter) >>> FRC_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      frc_q <= '0;
      adr_q <= '0;
    end else if (upd) begin
      y_q   <= yrl  ? sel      : (first ? '0 : y_q);
      frc_q <= frcl ? frc_next : (first ? '0 : frc_q);
      adr_q <= adrl ? adr_next : (first ? '0 : adr_q);
    end
  end
endmodule

// File: rtl/dsp_operand_front.sv
module dsp_operand_front
  import dsp_opfront_pkg::*;
#(
  parameter int DW      = 24,
  parameter int IRA_W   = 6,
  parameter int STEP_W  = 7,
  parameter int MEMS_N  = 32,
  parameter int MIX_N   = 16,
  parameter int MIX_W   = 20,
  parameter int EXT_N   = 2,
  parameter int EXT_W   = 16,
  parameter int PIPE_N  = 4,
  parameter int ADR_W   = 13,
  parameter int FRC_W   = 13,
  localparam int MAW    = $clog2(MEMS_N),
  localparam int PAW    = $clog2(PIPE_N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_valid,
  input  logic [STEP_W-1:0]      step_idx,
  input  logic [IRA_W-1:0]       ira,
  input  logic                   iwt,
  input  logic [MAW-1:0]         iwa,
  input  logic                   yrl,
  input  logic                   adrl,
  input  logic                   frcl,
  input  logic [1:0]             shift_mode,
  input  logic [DW-1:0]          shifter_in,
  input  logic [MIX_N*MIX_W-1:0] mixer_in,
  input  logic [EXT_N*EXT_W-1:0] ext_in,
  input  logic [PIPE_N*DW-1:0]   memval_in,
  output logic [DW-1:0]          sel_input,
  output logic [DW-1:0]          y_reg,
  output logic [FRC_W-1:0]       frc_reg,
  output logic [ADR_W-1:0]       adrs_reg
);
  logic [DW-1:0] mem_rd;
  logic          upd;
  logic          first;

  assign upd   = step_valid && !rst;
  assign first = (step_idx == '0);

  opf_latch_bank #(.DW(DW), .DEPTH(MEMS_N), .PIPE_N(PIPE_N)) u_bank (
    .clk       (clk),
    .we        (upd && iwt),
    .waddr     (iwa),
    .slot      (step_idx[PAW-1:0]),
    .memval_in (memval_in),
    .raddr     (ira[MAW-1:0]),
    .rdata     (mem_rd)
  );

  opf_source_mux #(
    .DW(DW), .IRA_W(IRA_W), .MEMS_N(MEMS_N), .MIX_N(MIX_N),
    .MIX_W(MIX_W), .EXT_N(EXT_N), .EXT_W(EXT_W)
  ) u_mux (
    .ira      (ira),
    .mem_rd   (mem_rd),
    .mixer_in (mixer_in),
    .ext_in   (ext_in),
    .sel      (sel_input)
  );

  opf_field_regs #(.DW(DW), .ADR_W(ADR_W), .FRC_W(FRC_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .first   (first),
    .yrl     (yrl),
    .adrl    (adrl),
    .frcl    (frcl),
    .mode    (shift_mode_e'(shift_mode)),
    .sel     (sel_input),
    .shifter (shifter_in),
    .y_q     (y_reg),
    .frc_q   (frc_reg),
    .adr_q   (adrs_reg)
  );
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int DW = 24, parameter int IRA_W = 6, parameter int STEP_W = 7,
  parameter int MEMS_N = 32, parameter int MIX_N = 16, parameter int EXT_N = 2,
  parameter int ADR_W = 13, parameter int FRC_W = 13,
  parameter int MIX_SH = 4, parameter int EXT_SH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step_valid,
  input logic [STEP_W-1:0] step_idx,
  input logic [IRA_W-1:0]  ira,
  input logic              yrl,
  input logic              frcl,
  input logic [1:0]        shift_mode,
  input logic [DW-1:0]     sel_input,
  input logic [DW-1:0]     y_reg,
  input logic [FRC_W-1:0]  frc_reg,
  input logic [ADR_W-1:0]  adrs_reg
);
  localparam int MIX_BASE = MEMS_N;
  localparam int EXT_BASE = MEMS_N + MIX_N;
  localparam int TOP_ADR  = EXT_BASE + EXT_N;

  // R4
  ira_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ira) >= TOP_ADR) |-> (sel_input == '0));
  // R2
  mix_align_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ira) >= MIX_BASE && int'(ira) < EXT_BASE) |-> (sel_input[MIX_SH-1:0] == '0));
  // R3
  ext_align_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ira) >= EXT_BASE && int'(ira) < TOP_ADR) |-> (sel_input[EXT_SH-1:0] == '0));
  // R5
  yreg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && yrl) |=> (y_reg == $past(sel_input)));
  // R8
  frc_low_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && frcl && shift_mode == 2'd3) |=> (frc_reg[FRC_W-1] == 1'b0));
  // R11
  first_step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_idx == '0 && !yrl) |=> (y_reg == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> ($stable(y_reg) && $stable(frc_reg) && $stable(adrs_reg)));
endmodule

bind dsp_operand_front opf_checker #(
  .DW(DW), .IRA_W(IRA_W), .STEP_W(STEP_W), .MEMS_N(MEMS_N), .MIX_N(MIX_N),
  .EXT_N(EXT_N), .ADR_W(ADR_W), .FRC_W(FRC_W),
  .MIX_SH(DW - MIX_W), .EXT_SH(DW - EXT_W)
) u_chk (
  .clk(clk), .rst(rst), .step_valid(step_valid), .step_idx(step_idx),
  .ira(ira), .yrl(yrl), .frcl(frcl), .shift_mode(shift_mode),
  .sel_input(sel_input), .y_reg(y_reg), .frc_reg(frc_reg), .adrs_reg(adrs_reg)
);

// File: tb/tb_dsp_operand_front.sv
module tb_dsp_operand_front;
  logic         clk = 0;
  logic         rst;
  logic         step_valid;
  logic [6:0]   step_idx;
  logic [5:0]   ira;
  logic         iwt;
  logic [4:0]   iwa;
  logic         yrl, adrl, frcl;
  logic [1:0]   shift_mode;
  logic [23:0]  shifter_in;
  logic [319:0] mixer_in;
  logic [31:0]  ext_in;
  logic [95:0]  memval_in;
  logic [23:0]  sel_input, y_reg;
  logic [12:0]  frc_reg, adrs_reg;

  always #5 clk = ~clk;

  dsp_operand_front dut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_idx(step_idx),
    .ira(ira), .iwt(iwt), .iwa(iwa), .yrl(yrl), .adrl(adrl), .frcl(frcl),
    .shift_mode(shift_mode), .shifter_in(shifter_in), .mixer_in(mixer_in),
    .ext_in(ext_in), .memval_in(memval_in), .sel_input(sel_input),
    .y_reg(y_reg), .frc_reg(frc_reg), .adrs_reg(adrs_reg)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [23:0] m_mem [32];
  logic [23:0] m_y;
  logic [12:0] m_frc, m_adr;
  int step_ctr = 0;

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_sel(int a);
    if (a < 32) return m_mem[a];
    if (a < 48) return 24'(int'($signed(mixer_in[(a-32)*20 +: 20])) * 16);
    if (a < 50) return 24'(int'($signed(ext_in[(a-48)*16 +: 16])) * 256);
    return 24'd0;
  endfunction

  function automatic string sel_tag(int a);
    if (a < 32) return "R1/R10";
    if (a < 48) return "R2";
    if (a < 50) return "R3";
    return "R4";
  endfunction

  task automatic randomize_data();
    for (int k = 0; k < 10; k++) mixer_in[k*32 +: 32] = $urandom;
    ext_in     = $urandom;
    memval_in  = {$urandom, $urandom, $urandom};
    shifter_in = 24'($urandom);
  endtask

  // one step: inputs already driven at a negedge; check sel, clock, check regs
  task automatic run_step(bit cmp_sel);
    logic [23:0] es;
    logic [23:0] ny;
    logic [12:0] nf, na;
    string ty, tf, ta;
    bit sh3, up, fst;
    #1;
    es = exp_sel(int'(ira));
    if (cmp_sel) chk(sel_tag(int'(ira)), sel_input, es);
    sh3 = (shift_mode == 2'd3);
    up  = step_valid && !rst;
    fst = (step_idx == 7'd0);
    ny = m_y; nf = m_frc; na = m_adr;
    ty = "R12"; tf = "R12"; ta = "R12";
    if (up) begin
      ty = "R11"; tf = "R11"; ta = "R11";
      if (fst) begin ny = 0; nf = 0; na = 0; end
      if (yrl) begin ny = es; ty = "R5"; end
      if (frcl) begin
        nf = sh3 ? 13'(shifter_in[11:0]) : 13'(int'($signed(shifter_in)) >>> 11);
        tf = sh3 ? "R8" : "R9";
      end
      if (adrl) begin
        na = sh3 ? 13'(int'($signed(shifter_in)) >>> 12) : 13'(int'($signed(es)) >>> 16);
        ta = sh3 ? "R6" : "R7";
      end
      if (iwt) m_mem[iwa] = memval_in[int'(step_idx[1:0])*24 +: 24];
    end
    if (rst) begin ny = 0; nf = 0; na = 0; ty = "R13"; tf = "R13"; ta = "R13"; end
    m_y = ny; m_frc = nf; m_adr = na;
    @(negedge clk);
    chk(ty, y_reg, m_y);
    chk(tf, 24'(frc_reg), 24'(m_frc));
    chk(ta, 24'(adrs_reg), 24'(m_adr));
  endtask

  task automatic set_op(bit v, int a, bit w, int wa, bit y, bit ad, bit f, int sm);
    step_valid = v; ira = 6'(a); iwt = w; iwa = 5'(wa);
    yrl = y; adrl = ad; frcl = f; shift_mode = 2'(sm);
    step_idx = 7'(step_ctr);
    if (v) step_ctr = (step_ctr + 1) % 128;
  endtask

  initial begin
    rst = 1; step_valid = 0; step_idx = 0; ira = 0; iwt = 0; iwa = 0;
    yrl = 0; adrl = 0; frcl = 0; shift_mode = 0;
    shifter_in = 0; mixer_in = 0; ext_in = 0; memval_in = 0;
    m_y = 0; m_frc = 0; m_adr = 0;
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    @(negedge clk); @(negedge clk);
    // R13 reset state
    chk("R13", y_reg, 24'd0);
    chk("R13", 24'(frc_reg), 24'd0);
    chk("R13", 24'(adrs_reg), 24'd0);
    rst = 0;
    // fill the latch bank (R10)
    for (int i = 0; i < 32; i++) begin
      randomize_data();
      set_op(1, 50, 1, i, 0, 0, 0, 0);
      run_step(1);
    end
    // same-step write and read of one entry (R10)
    randomize_data();
    set_op(1, 7, 1, 7, 1, 0, 0, 0);
    run_step(1);
    randomize_data();
    set_op(1, 7, 0, 0, 0, 0, 0, 0);
    run_step(1);
    // top addresses give zero (R4), strobe-less write ignored (R12)
    randomize_data();
    set_op(1, 63, 0, 0, 1, 1, 1, 3);
    run_step(1);
    randomize_data();
    set_op(0, 9, 1, 9, 1, 1, 1, 1);
    run_step(1);
    randomize_data();
    set_op(1, 9, 0, 0, 1, 1, 0, 2);
    run_step(1);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      randomize_data();
      set_op(($urandom % 5) != 0, $urandom % 64, $urandom % 2, $urandom % 32,
             $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
      if (n == 1500) begin
        rst = 1; step_valid = 0;
      end
      run_step(1);
      rst = 0;
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule